// File: doc/BRIEF.md
# Overcurrent Trip Latch and Gate-Drive Control

This block sits between two overcurrent comparators of a battery pack (one watching the charge direction, one the discharge direction) and the two open-drain gate drivers that switch the pack's charge and discharge paths. Each comparator output is asynchronous. It is brought into the clock domain first. A synchronized overcurrent then sets a sticky trip flag for its direction and raises a shared interrupt request.

Each gate output is an enable to pull low: 1 pulls the driver low and turns the path on, and 0 leaves it high-impedance, which turns the path off. A two-bit mode field for each direction selects how the gate follows the trip flag or the comparator. Host firmware reads the trip flags in a status word. It clears them and the interrupt with a clear pulse. An alert-response acknowledge also clears the interrupt. While the power-on timeout runs, both paths are held off.

Top module: `oc_guard`

## Requirements
- R1: Each comparator input passes through a two-flop synchronizer. In free-running mode, a change on the input that arrives before rising edge k shows on the pull-low output after edge k+1 and not before.
- R2: A direction's trip flag sets on the edge after its synchronized overcurrent is seen. It then holds until a `clr_int` pulse or `soft_shdn`. A clear that comes while the synchronized overcurrent is still present leaves the flag set. While `soft_shdn` is high, the flag stays clear.
- R3: The mode bits are `gate_mode[0]` = charge LO, `[1]` = charge HI, `[2]` = discharge LO and `[3]` = discharge HI. With HI=0 and LO=0, the output pulls low (1) while the trip flag is clear and is 0 once the flag is set.
- R4: With HI=0 and LO=1, the pull-low output is 1 whatever the comparator or the flag does.
- R5: With HI=1 and LO=0, the pull-low output is 0 whatever the comparator or the flag does.
- R6: With HI=1 and LO=1, the pull-low output is the inverse of the synchronized comparator. A persistent fault that turns on and off therefore pulses the output, while the trip flag and the interrupt stay latched.
- R7: While `por_wait` is high, both pull-low outputs are 0 in every mode.
- R8: `status_word` reads 1 in bits 15..8, the discharge trip flag in bit 7, the charge trip flag in bit 6, and 0 in bits 5..0.
- R9: `irq` sets on the edge after a synchronized overcurrent in either direction, whatever the mode. It holds until a `clr_int` or `alert_ack` pulse, and a new event in the same cycle wins over the clear. Soft shutdown does not clear it.
- R10: `alert_reply` always presents the alert-response byte 0x8F.
- R11: While `rst_n` is low, the synchronizers, the trip flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_oc_async | input | 1 | Charge-direction comparator, asynchronous |
| dis_oc_async | input | 1 | Discharge-direction comparator, asynchronous |
| gate_mode | input | 4 | HI/LO mode bits for each direction (see R3) |
| clr_int | input | 1 | Clear pulse for the trip flags and the interrupt |
| soft_shdn | input | 1 | Soft-shutdown level; holds the trip flags clear |
| por_wait | input | 1 | Power-on timeout active; forces both paths off |
| alert_ack | input | 1 | Alert-response acknowledge pulse; clears the interrupt |
| chg_pull_low | output | 1 | Charge gate driver: 1 pulls low, 0 high-impedance |
| dis_pull_low | output | 1 | Discharge gate driver: 1 pulls low, 0 high-impedance |
| status_word | output | 16 | Status word with the trip flags |
| irq | output | 1 | Interrupt request, active high |
| alert_reply | output | 8 | Byte returned on an alert-response query |

## Verification
Two things can land in the same cycle: a clear pulse (`clr_int` or `alert_ack`) and a synchronized overcurrent that is still present. The bench holds a comparator high across a clear. It also times a clear to land exactly on the edge where a fresh event first reaches the synchronizer output. In both cases it expects the trip flag and `irq` to stay set, because the event wins. A second collision is provoked by running free-running mode under a pulsing fault. The gate output must toggle every time the comparator does, while `irq` and the flag stay latched. All of these are judged against a behavioural model that is compared on every clock.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;

  localparam int NUM_DIR = 2;
  localparam int DIR_CHG = 0;
  localparam int DIR_DIS = 1;

  // encoding is {HI, LO}
  typedef enum logic [1:0] {
    GM_AUTO      = 2'b00,
    GM_FORCE_ON  = 2'b01,
    GM_FORCE_OFF = 2'b10,
    GM_FREE      = 2'b11
  } gate_mode_e;

  // 1 = pull gate low (path on), 0 = high-impedance (path off)
  function automatic logic gate_pull_low(gate_mode_e mode, logic oc_now,
                                         logic tripped, logic hold_off);
    logic pl;
    case (mode)
      GM_AUTO:      pl = ~tripped;
      GM_FORCE_ON:  pl = 1'b1;
      GM_FORCE_OFF: pl = 1'b0;
      default:      pl = ~oc_now;
    endcase
    return pl & ~hold_off;
  endfunction

  // set wins over clear; shutdown holds the flag clear
  function automatic logic trip_next(logic oc_now, logic tripped,
                                     logic clr, logic shutdown);
    return ~shutdown & (oc_now | (tripped & ~clr));
  endfunction

endpackage

// File: rtl/oc_sync.sv
module oc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= d_async;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[k] <= 1'b0;
      else        chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/oc_trip_path.sv
module oc_trip_path
  import oc_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oc_now,
  input  logic [1:0] mode_bits,
  input  logic       clr,
  input  logic       shutdown,
  input  logic       hold_off,
  output logic       tripped,
  output logic       pull_low
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tripped <= 1'b0;
    else        tripped <= trip_next(oc_now, tripped, clr, shutdown);
  end

  assign pull_low = gate_pull_low(gate_mode_e'(mode_bits), oc_now, tripped, hold_off);
endmodule

// File: rtl/oc_irq.sv
module oc_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  input  logic         ack,
  output logic         irq
);
  logic any_evt;
  assign any_evt = |evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_evt | (irq & ~(clr | ack));
  end
endmodule

// File: rtl/oc_guard.sv
module oc_guard
  import oc_guard_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  REPLY_BYTE  = 8'h8F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chg_oc_async,
  input  logic        dis_oc_async,
  input  logic [3:0]  gate_mode,
  input  logic        clr_int,
  input  logic        soft_shdn,
  input  logic        por_wait,
  input  logic        alert_ack,
  output logic        chg_pull_low,
  output logic        dis_pull_low,
  output logic [15:0] status_word,
  output logic        irq,
  output logic [7:0]  alert_reply
);
  localparam int LOW_PAD = 6;

  logic [NUM_DIR-1:0] oc_raw;
  logic [NUM_DIR-1:0] oc_evt;    // synchronized overcurrent per direction
  logic [NUM_DIR-1:0] tripped;   // sticky trip flag per direction
  logic [NUM_DIR-1:0] pull_low;

  assign oc_raw[DIR_CHG] = chg_oc_async;
  assign oc_raw[DIR_DIS] = dis_oc_async;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    oc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(oc_raw[d]),
      .q      (oc_evt[d])
    );
    oc_trip_path u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .oc_now   (oc_evt[d]),
      .mode_bits(gate_mode[2*d +: 2]),
      .clr      (clr_int),
      .shutdown (soft_shdn),
      .hold_off (por_wait),
      .tripped  (tripped[d]),
      .pull_low (pull_low[d])
    );
  end

  oc_irq #(.N(NUM_DIR)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (oc_evt),
    .clr  (clr_int),
    .ack  (alert_ack),
    .irq  (irq)
  );

  assign chg_pull_low = pull_low[DIR_CHG];
  assign dis_pull_low = pull_low[DIR_DIS];
  assign status_word  = {8'hFF, tripped[DIR_DIS], tripped[DIR_CHG], {LOW_PAD{1'b0}}};
  assign alert_reply  = REPLY_BYTE;
endmodule

// File: rtl/oc_guard_chk.sv
module oc_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  gate_mode,
  input logic        clr_int,
  input logic        soft_shdn,
  input logic        por_wait,
  input logic        alert_ack,
  input logic        chg_pull_low,
  input logic        dis_pull_low,
  input logic [15:0] status_word,
  input logic        irq,
  input logic [1:0]  oc_evt
);
  AST_POR_PATHS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    por_wait |-> (!chg_pull_low && !dis_pull_low)); // R7

  AST_FORCE_ON_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_wait && gate_mode[1:0] == 2'b01) |-> chg_pull_low); // R4

  AST_FORCE_OFF_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_mode[3:2] == 2'b10) |-> !dis_pull_low); // R5

  AST_AUTO_FOLLOWS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_wait && gate_mode[1:0] == 2'b00) |-> (chg_pull_low == !status_word[6])); // R3

  AST_FREE_FOLLOWS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_wait && gate_mode[3:2] == 2'b11) |-> (dis_pull_low == !oc_evt[1])); // R6

  AST_TRIP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_evt[0] && !soft_shdn) |=> status_word[6]); // R2

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[7] && !clr_int && !soft_shdn) |=> status_word[7]); // R2

  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_evt) |=> irq); // R9

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_int && !alert_ack) |=> irq); // R9
endmodule

bind oc_guard oc_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_mode   (gate_mode),
  .clr_int     (clr_int),
  .soft_shdn   (soft_shdn),
  .por_wait    (por_wait),
  .alert_ack   (alert_ack),
  .chg_pull_low(chg_pull_low),
  .dis_pull_low(dis_pull_low),
  .status_word (status_word),
  .irq         (irq),
  .oc_evt      (oc_evt)
);

// File: tb/oc_guard_test.sv
`timescale 1ns/1ps
module oc_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chg_oc_async = 1'b0, dis_oc_async = 1'b0;
  logic [3:0]  gate_mode = 4'b0000;
  logic        clr_int = 1'b0, soft_shdn = 1'b0, por_wait = 1'b0, alert_ack = 1'b0;
  logic        chg_pull_low, dis_pull_low, irq;
  logic [15:0] status_word;
  logic [7:0]  alert_reply;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  oc_guard uut (
    .clk(clk), .rst_n(rst_n), .chg_oc_async(chg_oc_async), .dis_oc_async(dis_oc_async),
    .gate_mode(gate_mode), .clr_int(clr_int), .soft_shdn(soft_shdn), .por_wait(por_wait),
    .alert_ack(alert_ack), .chg_pull_low(chg_pull_low), .dis_pull_low(dis_pull_low),
    .status_word(status_word), .irq(irq), .alert_reply(alert_reply)
  );

  // behavioural reference: pipeline stages kept as a small queue per direction
  bit q_chg[$] = '{0, 0};
  bit q_dis[$] = '{0, 0};
  bit m_trip[2] = '{0, 0};
  bit m_irq = 0;

  task automatic model_step();
    bit seen_c, seen_d;
    if (!rst_n) begin
      q_chg = '{0, 0}; q_dis = '{0, 0};
      m_trip[0] = 0; m_trip[1] = 0; m_irq = 0;
      return;
    end
    seen_c = q_chg[0];
    seen_d = q_dis[0];
    m_irq = seen_c || seen_d || (m_irq && !clr_int && !alert_ack);
    m_trip[0] = soft_shdn ? 0 : (seen_c ? 1 : (clr_int ? 0 : m_trip[0]));
    m_trip[1] = soft_shdn ? 0 : (seen_d ? 1 : (clr_int ? 0 : m_trip[1]));
    void'(q_chg.pop_front()); q_chg.push_back(chg_oc_async);
    void'(q_dis.pop_front()); q_dis.push_back(dis_oc_async);
  endtask

  function automatic bit seen_now(int d);
    return (d == 0) ? q_chg[0] : q_dis[0];
  endfunction

  function automatic bit want_pull(int d);
    bit hi = gate_mode[2*d+1];
    bit lo = gate_mode[2*d];
    if (por_wait) return 0;
    if (!hi && !lo) return !m_trip[d];
    if (!hi && lo)  return 1;
    if (hi && !lo)  return 0;
    return !seen_now(d);
  endfunction

  function automatic string pull_req(int d);
    bit hi = gate_mode[2*d+1];
    bit lo = gate_mode[2*d];
    if (por_wait) return "R7";
    if (!hi && !lo) return "R3";
    if (!hi && lo)  return "R4";
    if (hi && !lo)  return "R5";
    return "R6";
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(pull_req(0), "chg_pull_low", {15'd0, chg_pull_low}, {15'd0, want_pull(0)});
    check(pull_req(1), "dis_pull_low", {15'd0, dis_pull_low}, {15'd0, want_pull(1)});
    check("R8", "status_word", status_word, {8'hFF, m_trip[1], m_trip[0], 6'b0});
    check("R9", "irq", {15'd0, irq}, {15'd0, m_irq});
    check("R10", "alert_reply", {8'd0, alert_reply}, 16'h008F);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_step();
      compare_all();
    end
  endtask

  task automatic pulse_clr();
    clr_int = 1; step(1); clr_int = 0;
  endtask

  initial begin
    // R11: reset state
    step(2);
    check("R11", "irq in reset", {15'd0, irq}, 16'd0);
    check("R11", "status in reset", status_word, 16'hFF00);
    rst_n = 1;
    step(2);

    // R3 / R2: auto mode, one-cycle charge fault latches
    chg_oc_async = 1; step(1); chg_oc_async = 0;
    step(2);
    check("R2", "chg trip after pulse", {15'd0, status_word[6]}, 16'd1);
    check("R3", "auto path off after trip", {15'd0, chg_pull_low}, 16'd0);
    step(3);
    pulse_clr(); step(1);
    check("R2", "chg trip cleared", {15'd0, status_word[6]}, 16'd0);

    // discharge side in auto, then clear while fault still present (set wins)
    dis_oc_async = 1; step(4);
    pulse_clr();
    check("R2", "dis trip held over clear", {15'd0, status_word[7]}, 16'd1);
    check("R9", "irq held over clear", {15'd0, irq}, 16'd1);
    dis_oc_async = 0; step(3);
    pulse_clr(); step(1);

    // clear landing exactly where a fresh event reaches the synchronizer output
    chg_oc_async = 1; step(1); chg_oc_async = 0; step(1);
    pulse_clr(); step(2);

    // R9: alert acknowledge clears irq only
    dis_oc_async = 1; step(1); dis_oc_async = 0; step(3);
    alert_ack = 1; step(1); alert_ack = 0; step(1);
    check("R9", "irq after ack", {15'd0, irq}, 16'd0);
    check("R2", "trip kept after ack", {15'd0, status_word[7]}, 16'd1);

    // soft shutdown clears trips, not irq
    chg_oc_async = 1; step(1); chg_oc_async = 0; step(3);
    soft_shdn = 1; step(2);
    check("R2", "trips cleared in soft shutdown", status_word, 16'hFF00);
    check("R9", "irq survives soft shutdown", {15'd0, irq}, 16'd1);
    chg_oc_async = 1; step(3); chg_oc_async = 0; step(3);
    soft_shdn = 0; pulse_clr(); step(1);

    // R4 / R5: forced modes with faults present
    gate_mode = 4'b1001; // chg forced on, dis forced off
    chg_oc_async = 1; dis_oc_async = 1; step(4);
    check("R4", "forced on under fault", {15'd0, chg_pull_low}, 16'd1);
    check("R5", "forced off", {15'd0, dis_pull_low}, 16'd0);
    chg_oc_async = 0; dis_oc_async = 0; step(3);
    gate_mode = 4'b0110; step(2); // chg forced off, dis forced on
    pulse_clr(); step(2);

    // R6 / R1: free-running on both sides, pulsing fault
    gate_mode = 4'b1111; step(2);
    chg_oc_async = 1; step(1);
    check("R1", "chg still on one edge after change", {15'd0, chg_pull_low}, 16'd1);
    step(1);
    check("R1", "chg off two edges after change", {15'd0, chg_pull_low}, 16'd0);
    for (int i = 0; i < 12; i++) begin
      chg_oc_async = i[0]; dis_oc_async = i[1]; step(1);
    end
    chg_oc_async = 0; dis_oc_async = 0; step(3);
    check("R6", "irq latched in free-running", {15'd0, irq}, 16'd1);
    check("R6", "chg on again after fault gone", {15'd0, chg_pull_low}, 16'd1);
    pulse_clr(); step(1);

    // R7: power-on timeout over every mode
    por_wait = 1;
    for (int m = 0; m < 16; m++) begin
      gate_mode = m[3:0]; step(1);
      check("R7", "chg off in timeout", {15'd0, chg_pull_low}, 16'd0);
    end
    por_wait = 0; gate_mode = 4'b0000; step(2);

    // R11: reset in mid-run with flags set
    dis_oc_async = 1; step(4);
    rst_n = 0; step(1);
    check("R11", "status after reset", status_word, 16'hFF00);
    check("R11", "irq after reset", {15'd0, irq}, 16'd0);
    dis_oc_async = 0; step(1); rst_n = 1; step(4);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule